// File: doc/BRIEF.md
# Cassette Motion Start and Gap Tracker

This block sequences the start of every tape command for a pair of cassette drives. A one-cycle GO strobe, a 3-bit function code and a unit select launch a command. The block first checks the selected drive for a loaded cartridge and, for writes, for write protection. It then runs the lead-in steps that cassette media need, checks the motion against the tape ends, and issues the main motion. Each record-sized piece of motion is passed to an external transport as a request, and the transport answers with a completion pulse. When the command ends, the block reports a one-cycle completion with a set of status flags for the status register.

Cassettes mark files with gaps, not with written marks. A gap that the tape has just crossed must not be reported a second time when the tape changes direction. For this reason the block keeps two history bits per drive: the direction of the last read or space command, and whether the last command on that drive ended on a gap. A forward read or space started at the beginning of tape also steps over the leading gap that every cassette carries. The tape data itself, character transfer and register access are all handled outside the block.

Top module: `cas_motion_ctl`

## Requirements
- R1: The function codes are: 0 write gap, 1 write data, 2 read, 3 space file reverse, 4 space block reverse, 5 space file forward, 6 space block forward, 7 rewind. Codes 0, 1, 2, 5 and 6 move the tape forward. Codes 3 and 4 move it in reverse. Rewind counts as neither direction for the end-of-tape check.
- R2: A GO to a unit with no cartridge completes in the next cycle with flags error (bit 0) and empty (bit 5) and issues no motion request. This check comes before every other check.
- R3: A write-gap or write-data GO to a write-protected unit completes in the next cycle with error (bit 0) and write-lock (bit 3) and issues no motion. Write protection has no effect on the other codes.
- R4: A forward read or space that starts at the beginning of tape first steps forward one record. If that record is a gap, the command goes on from the position after it. If it is not a gap, the block issues a return-to-BOT request before it goes on.
- R5: A read or space command whose direction differs from the unit's stored direction, while the stored gap bit is set, first steps one record silently in the new direction. A gap that R4 skipped in the same command cancels this step.
- R6: Each unit holds a direction bit (1 = reverse) and a gap bit. A read or space command stores its own direction with the gap bit cleared. Write gap, write data and rewind clear both bits. The gap bit is set when a command on that unit completes with the EOF flag (bit 4).
- R7: After the lead-in steps, a forward command at end of tape, or a reverse command at beginning of tape, completes with error (bit 0) and tape-end (bit 2) and issues no main motion.
- R8: A space file command repeats single-record steps until it crosses a gap and then completes with EOF and no error. If the transport reports a blocked step first, the command completes with error and tape-end.
- R9: A space block command takes one step. Crossing a gap gives error and EOF. A forward space block always sets the CRC flag (bit 1).
- R10: Rewind issues one rewind request and completes with tape-end set and no error.
- R11: Read issues one read-data request, and a gap read gives error and EOF. Write gap and write data each issue one request and complete with no flags.
- R12: A GO that arrives while a command is in progress is ignored.
- R13: Motion request codes are 0 step forward, 1 step reverse, 2 write gap, 3 write data, 4 read data, 5 rewind, 6 return to BOT. `mv_req` is a one-cycle pulse, and only one request is outstanding at a time. `busy` is high from acceptance until completion. `cmp_valid` is a one-cycle pulse for each accepted GO. After reset, `busy`, `mv_req` and `cmp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Command start strobe |
| func | input | 3 | Function code |
| unit | input | UW | Drive select |
| cart_present | input | N_UNITS | Cartridge loaded, per drive |
| write_prot | input | N_UNITS | Write protect, per drive |
| at_bot | input | N_UNITS | Tape at beginning, per drive |
| at_eot | input | N_UNITS | Tape at end, per drive |
| mv_req | output | 1 | Motion request pulse |
| mv_op | output | 3 | Motion request code |
| mv_unit | output | UW | Drive for the request |
| mv_done | input | 1 | Transport completion pulse |
| mv_gap | input | 1 | The step crossed a gap |
| mv_edge | input | 1 | The step was blocked by a tape end |
| busy | output | 1 | Command in progress |
| cmp_valid | output | 1 | Command completion pulse |
| cmp_flags | output | 6 | Completion flags: error, CRC, tape-end, write-lock, EOF, empty (bits 0 to 5) |

## Verification
The assertions assume that the transport raises `mv_done` only for a request that is outstanding, as a one-cycle pulse, and at least one cycle after the request. They also assume that the tape-end and cartridge inputs change only while the transport is acting on a request, or between commands. The bench transport model updates tape position only when it answers a request. Drive status is changed only while the block is idle, and GO during a command is given only in the dedicated busy test.

// File: rtl/cas_pkg.sv
package cas_pkg;

  typedef enum logic [2:0] {
    FN_GAPWR    = 3'd0,
    FN_WRITE    = 3'd1,
    FN_READ     = 3'd2,
    FN_FILE_REV = 3'd3,
    FN_BLK_REV  = 3'd4,
    FN_FILE_FWD = 3'd5,
    FN_BLK_FWD  = 3'd6,
    FN_REWIND   = 3'd7
  } fn_e;

  typedef enum logic [2:0] {
    MV_STEP_FWD = 3'd0,
    MV_STEP_REV = 3'd1,
    MV_WR_GAP   = 3'd2,
    MV_WR_DATA  = 3'd3,
    MV_RD_DATA  = 3'd4,
    MV_REWIND   = 3'd5,
    MV_TO_BOT   = 3'd6
  } mv_e;

  localparam int FL_W     = 6;
  localparam int FL_ERR   = 0;
  localparam int FL_CRC   = 1;
  localparam int FL_EDGE  = 2;
  localparam int FL_WLK   = 3;
  localparam int FL_EOF   = 4;
  localparam int FL_EMPTY = 5;

  typedef logic [FL_W-1:0] flags_t;

  typedef struct packed {
    logic   again;
    flags_t fl;
  } step_res_t;

  function automatic logic fn_writes(fn_e f);
    return (f == FN_GAPWR) || (f == FN_WRITE);
  endfunction

  function automatic logic fn_rev(fn_e f);
    return (f == FN_FILE_REV) || (f == FN_BLK_REV);
  endfunction

  function automatic logic fn_fwd(fn_e f);
    return !fn_rev(f) && (f != FN_REWIND);
  endfunction

  function automatic logic fn_moves(fn_e f);
    return !fn_writes(f) && (f != FN_REWIND);
  endfunction

  // history bit 1 = reverse, bit 0 = ended on gap
  function automatic logic [1:0] hist_new(fn_e f);
    return fn_moves(f) ? {fn_rev(f), 1'b0} : 2'b00;
  endfunction

  function automatic logic need_skip(logic [1:0] old_h, logic rev);
    return old_h[0] && (old_h[1] != rev);
  endfunction

  function automatic mv_e main_op(fn_e f);
    case (f)
      FN_GAPWR:               return MV_WR_GAP;
      FN_WRITE:               return MV_WR_DATA;
      FN_READ:                return MV_RD_DATA;
      FN_FILE_REV, FN_BLK_REV: return MV_STEP_REV;
      FN_FILE_FWD, FN_BLK_FWD: return MV_STEP_FWD;
      default:                return MV_REWIND;
    endcase
  endfunction

  function automatic step_res_t step_eval(fn_e f, logic gap, logic blk);
    step_res_t r;
    r = '0;
    if (blk) begin
      r.fl[FL_ERR]  = 1'b1;
      r.fl[FL_EDGE] = 1'b1;
      if (f == FN_BLK_FWD) r.fl[FL_CRC] = 1'b1;
    end else begin
      case (f)
        FN_READ, FN_BLK_REV: begin
          r.fl[FL_ERR] = gap;
          r.fl[FL_EOF] = gap;
        end
        FN_BLK_FWD: begin
          r.fl[FL_CRC] = 1'b1;
          r.fl[FL_ERR] = gap;
          r.fl[FL_EOF] = gap;
        end
        FN_FILE_REV, FN_FILE_FWD: begin
          r.fl[FL_EOF] = gap;
          r.again      = !gap;
        end
        FN_REWIND: r.fl[FL_EDGE] = 1'b1;
        default:   r.fl = '0;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/cas_hist.sv
module cas_hist #(
  parameter int N_UNITS = 2,
  parameter int UW      = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [UW-1:0] wr_unit,
  input  logic [1:0]    wr_val,
  input  logic          gap_set,
  input  logic [UW-1:0] gap_unit,
  input  logic [UW-1:0] rd_unit,
  output logic [1:0]    rd_val
);

  logic [1:0] hist [N_UNITS];

  for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        hist[g] <= 2'b00;
      else if (wr_en && (wr_unit == UW'(g)))
        hist[g] <= wr_val;
      else if (gap_set && (gap_unit == UW'(g)))
        hist[g][0] <= 1'b1;
    end
  end

  assign rd_val = hist[rd_unit];

endmodule

// File: rtl/cas_seq.sv
module cas_seq
  import cas_pkg::*;
#(
  parameter int UW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [2:0]    func,
  input  logic [UW-1:0] unit,
  input  logic          present_go,
  input  logic          wprot_go,
  input  logic          bot_cur,
  input  logic          eot_cur,
  input  logic [1:0]    hist_rd,
  output logic          hist_we,
  output logic [1:0]    hist_wval,
  output logic          hist_gap_set,
  output logic [UW-1:0] unit_q,
  output logic          mv_req,
  output mv_e           mv_op,
  input  logic          mv_done,
  input  logic          mv_gap,
  input  logic          mv_edge,
  output logic          busy,
  output logic          cmp_valid,
  output flags_t        cmp_flags
);

  typedef enum logic [2:0] {
    S_IDLE, S_BOT, W_BOT, W_RST, S_REV, W_SKIP, S_MAIN, W_MAIN
  } st_e;

  st_e        state, nxt;
  fn_e        fgo, func_q;
  logic [1:0] old_q;
  logic       supp_q, supp_set;
  logic       issue, fin;
  mv_e        op;
  flags_t     fin_flags;
  step_res_t  res;

  // named internal events
  logic go_accept, main_done;

  assign fgo       = fn_e'(func);
  assign go_accept = (state == S_IDLE) && go && present_go &&
                     !(fn_writes(fgo) && wprot_go);
  assign main_done = (state == W_MAIN) && mv_done;
  assign res       = step_eval(func_q, mv_gap, mv_edge);

  always_comb begin
    nxt       = state;
    issue     = 1'b0;
    op        = MV_STEP_FWD;
    fin       = 1'b0;
    fin_flags = '0;
    supp_set  = 1'b0;
    case (state)
      S_IDLE: if (go) begin
        if (!present_go) begin
          fin = 1'b1;
          fin_flags[FL_ERR]   = 1'b1;
          fin_flags[FL_EMPTY] = 1'b1;
        end else if (fn_writes(fgo) && wprot_go) begin
          fin = 1'b1;
          fin_flags[FL_ERR] = 1'b1;
          fin_flags[FL_WLK] = 1'b1;
        end else begin
          nxt = S_BOT;
        end
      end
      S_BOT: begin
        if (fn_moves(func_q) && fn_fwd(func_q) && bot_cur) begin
          issue = 1'b1;
          op    = MV_STEP_FWD;
          nxt   = W_BOT;
        end else begin
          nxt = S_REV;
        end
      end
      W_BOT: if (mv_done) begin
        if (mv_gap && !mv_edge) begin
          supp_set = 1'b1;
          nxt      = S_REV;
        end else begin
          issue = 1'b1;
          op    = MV_TO_BOT;
          nxt   = W_RST;
        end
      end
      W_RST: if (mv_done) nxt = S_REV;
      S_REV: begin
        if (fn_moves(func_q) && !supp_q && need_skip(old_q, fn_rev(func_q))) begin
          issue = 1'b1;
          op    = fn_rev(func_q) ? MV_STEP_REV : MV_STEP_FWD;
          nxt   = W_SKIP;
        end else begin
          nxt = S_MAIN;
        end
      end
      W_SKIP: if (mv_done) nxt = S_MAIN;
      S_MAIN: begin
        if ((fn_fwd(func_q) && eot_cur) || (fn_rev(func_q) && bot_cur)) begin
          fin = 1'b1;
          fin_flags[FL_ERR]  = 1'b1;
          fin_flags[FL_EDGE] = 1'b1;
          nxt = S_IDLE;
        end else begin
          issue = 1'b1;
          op    = main_op(func_q);
          nxt   = W_MAIN;
        end
      end
      W_MAIN: if (main_done) begin
        if (res.again) begin
          issue = 1'b1;
          op    = main_op(func_q);
        end else begin
          fin       = 1'b1;
          fin_flags = res.fl;
          nxt       = S_IDLE;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      func_q    <= FN_GAPWR;
      unit_q    <= '0;
      old_q     <= 2'b00;
      supp_q    <= 1'b0;
      mv_req    <= 1'b0;
      mv_op     <= MV_STEP_FWD;
      cmp_valid <= 1'b0;
      cmp_flags <= '0;
    end else begin
      state     <= nxt;
      mv_req    <= issue;
      cmp_valid <= fin;
      if (issue) mv_op <= op;
      if (fin) cmp_flags <= fin_flags;
      if (go_accept) begin
        func_q <= fgo;
        unit_q <= unit;
        old_q  <= hist_rd;
        supp_q <= 1'b0;
      end else if (supp_set) begin
        supp_q <= 1'b1;
      end
    end
  end

  assign busy         = (state != S_IDLE);
  assign hist_we      = go_accept;
  assign hist_wval    = hist_new(fgo);
  assign hist_gap_set = fin && fin_flags[FL_EOF] && (state != S_IDLE);

endmodule

// File: rtl/cas_motion_ctl.sv
module cas_motion_ctl
  import cas_pkg::*;
#(
  parameter  int N_UNITS = 2,
  localparam int UW      = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [2:0]         func,
  input  logic [UW-1:0]      unit,
  input  logic [N_UNITS-1:0] cart_present,
  input  logic [N_UNITS-1:0] write_prot,
  input  logic [N_UNITS-1:0] at_bot,
  input  logic [N_UNITS-1:0] at_eot,
  output logic               mv_req,
  output logic [2:0]         mv_op,
  output logic [UW-1:0]      mv_unit,
  input  logic               mv_done,
  input  logic               mv_gap,
  input  logic               mv_edge,
  output logic               busy,
  output logic               cmp_valid,
  output logic [5:0]         cmp_flags
);

  logic          hist_we, hist_gap_set;
  logic [1:0]    hist_wval, hist_rd;
  logic [UW-1:0] unit_q;
  mv_e           op_e;
  flags_t        flags_w;

  cas_hist #(.N_UNITS(N_UNITS), .UW(UW)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (hist_we),
    .wr_unit  (unit),
    .wr_val   (hist_wval),
    .gap_set  (hist_gap_set),
    .gap_unit (unit_q),
    .rd_unit  (unit),
    .rd_val   (hist_rd)
  );

  cas_seq #(.UW(UW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .go           (go),
    .func         (func),
    .unit         (unit),
    .present_go   (cart_present[unit]),
    .wprot_go     (write_prot[unit]),
    .bot_cur      (at_bot[unit_q]),
    .eot_cur      (at_eot[unit_q]),
    .hist_rd      (hist_rd),
    .hist_we      (hist_we),
    .hist_wval    (hist_wval),
    .hist_gap_set (hist_gap_set),
    .unit_q       (unit_q),
    .mv_req       (mv_req),
    .mv_op        (op_e),
    .mv_done      (mv_done),
    .mv_gap       (mv_gap),
    .mv_edge      (mv_edge),
    .busy         (busy),
    .cmp_valid    (cmp_valid),
    .cmp_flags    (flags_w)
  );

  assign mv_op     = op_e;
  assign mv_unit   = unit_q;
  assign cmp_flags = flags_w;

endmodule

// File: rtl/cas_motion_chk.sv
module cas_motion_chk
  import cas_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       go,
  input logic [2:0] func,
  input logic       busy,
  input logic       mv_req,
  input logic       cmp_valid,
  input logic [5:0] cmp_flags
);

  logic [2:0] cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cmd_q <= 3'd0;
    else if (go && !busy) cmd_q <= func;
  end

  assert_req_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mv_req |=> !mv_req);

  assert_req_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mv_req |-> busy);

  assert_cmp_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> !cmp_valid);

  assert_cmp_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |-> !busy);

  assert_empty_still_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_flags[FL_EMPTY]) |-> (cmp_flags[FL_ERR] && !$past(busy)));

  assert_wlk_still_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_flags[FL_WLK]) |-> (cmp_flags[FL_ERR] && !$past(busy)));

  assert_file_eof_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && ((cmd_q == 3'd3) || (cmd_q == 3'd5)) && !cmp_flags[FL_ERR])
      |-> cmp_flags[FL_EOF]);

  assert_blkfwd_crc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && (cmd_q == 3'd6) && !cmp_flags[FL_EMPTY] && !cmp_flags[FL_EDGE])
      |-> cmp_flags[FL_CRC]);

  assert_rewind_bot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && (cmd_q == 3'd7) && !cmp_flags[FL_EMPTY])
      |-> (cmp_flags[FL_EDGE] && !cmp_flags[FL_ERR]));

endmodule

bind cas_motion_ctl cas_motion_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .go        (go),
  .func      (func),
  .busy      (busy),
  .mv_req    (mv_req),
  .cmp_valid (cmp_valid),
  .cmp_flags (cmp_flags)
);

// File: tb/cas_motion_ctl_bench.sv
module cas_motion_ctl_bench;

  localparam int N   = 2;
  localparam int LEN = 12;
  // flag bit positions from the requirements
  localparam int B_ERR = 0, B_CRC = 1, B_EDGE = 2, B_WLK = 3, B_EOF = 4, B_EMPTY = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       go;
  logic [2:0] func;
  logic [0:0] unit;
  logic [N-1:0] present, wprot, at_bot, at_eot;
  logic       mv_req, mv_done, mv_gap, mv_edge, busy, cmp_valid;
  logic [2:0] mv_op;
  logic [0:0] mv_unit;
  logic [5:0] cmp_flags;

  always #10 clk = ~clk;

  cas_motion_ctl u_cas_motion_ctl (
    .clk(clk), .rst_n(rst_n), .go(go), .func(func), .unit(unit),
    .cart_present(present), .write_prot(wprot), .at_bot(at_bot), .at_eot(at_eot),
    .mv_req(mv_req), .mv_op(mv_op), .mv_unit(mv_unit),
    .mv_done(mv_done), .mv_gap(mv_gap), .mv_edge(mv_edge),
    .busy(busy), .cmp_valid(cmp_valid), .cmp_flags(cmp_flags)
  );

  // tape model
  bit trec [N][16];
  int tpos [N];
  bit rrec [N][16];
  int rpos [N];
  bit [1:0] rhist [N];

  assign at_bot = {tpos[1] == 0, tpos[0] == 0};
  assign at_eot = {tpos[1] == LEN, tpos[0] == LEN};

  int nchk = 0, nfail = 0, nreq = 0, ncmp = 0, cycles = 0;
  bit last_req = 0;

  task automatic chk(string tag, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic do_op(int u, int op);
    mv_gap = 0; mv_edge = 0;
    case (op)
      0, 4: if (tpos[u] == LEN) mv_edge = 1;
            else begin mv_gap = trec[u][tpos[u]]; tpos[u]++; end
      1:    if (tpos[u] == 0) mv_edge = 1;
            else begin tpos[u]--; mv_gap = trec[u][tpos[u]]; end
      2, 3: if (tpos[u] == LEN) mv_edge = 1;
            else begin trec[u][tpos[u]] = (op == 2); tpos[u]++; end
      default: tpos[u] = 0;
    endcase
  endtask

  // transport responder
  initial begin
    mv_done = 0; mv_gap = 0; mv_edge = 0;
    forever begin
      @(negedge clk);
      mv_done = 0;
      if (mv_req) begin
        int op, u;
        op = mv_op; u = mv_unit; nreq++;
        @(negedge clk);
        do_op(u, op);
        mv_done = 1;
      end
    end
  end

  // monitor and watchdog
  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      if (mv_req && last_req) chk("R13", "req pulse width", 2, 1);
      last_req = mv_req;
      if (cmp_valid) ncmp++;
      if (cycles > 150000) begin
        chk("watchdog", "timeout", 1, 0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
      end
    end
  end

  task automatic rstep(int u, bit fwd, output bit g, output bit e);
    g = 0; e = 0;
    if (fwd) begin
      if (rpos[u] == LEN) e = 1; else begin g = rrec[u][rpos[u]]; rpos[u]++; end
    end else begin
      if (rpos[u] == 0) e = 1; else begin rpos[u]--; g = rrec[u][rpos[u]]; end
    end
  endtask

  // reference model built from the requirements
  task automatic ref_cmd(int u, int f, output logic [5:0] ef);
    bit rev, fwd, sup, g, e;
    bit [1:0] old;
    ef = 0;
    if (!present[u]) begin ef[B_ERR] = 1; ef[B_EMPTY] = 1; return; end
    if (f <= 1 && wprot[u]) begin ef[B_ERR] = 1; ef[B_WLK] = 1; return; end
    rev = (f == 3 || f == 4);
    fwd = !rev && f != 7;
    if (f >= 2 && f <= 6) begin
      old = rhist[u]; rhist[u] = {rev, 1'b0}; sup = 0;
      if (fwd && rpos[u] == 0) begin
        rstep(u, 1, g, e);
        if (g && !e) sup = 1; else rpos[u] = 0;
      end
      if (!sup && old[0] && old[1] != rev) rstep(u, fwd, g, e);
    end else rhist[u] = 2'b00;
    if ((fwd && rpos[u] == LEN) || (rev && rpos[u] == 0)) begin
      ef[B_ERR] = 1; ef[B_EDGE] = 1; return;
    end
    case (f)
      0, 1: begin rrec[u][rpos[u]] = (f == 0); rpos[u]++; end
      2, 4: begin rstep(u, f == 2, g, e); if (g) begin ef[B_ERR] = 1; ef[B_EOF] = 1; end end
      6:    begin rstep(u, 1, g, e); ef[B_CRC] = 1; if (g) begin ef[B_ERR] = 1; ef[B_EOF] = 1; end end
      3, 5: begin
        do begin rstep(u, f == 5, g, e); end while (!g && !e);
        if (e) begin ef[B_ERR] = 1; ef[B_EDGE] = 1; end else ef[B_EOF] = 1;
      end
      default: begin rpos[u] = 0; ef[B_EDGE] = 1; end
    endcase
    if (ef[B_EOF]) rhist[u][0] = 1;
  endtask

  task automatic run_cmd(string tag, int u, int f, bit poke);
    logic [5:0] ef;
    int c0, r0, t;
    rrec = trec; rpos = tpos;
    ref_cmd(u, f, ef);
    c0 = ncmp; r0 = nreq;
    @(negedge clk);
    go = 1; func = 3'(f); unit = 1'(u);
    @(negedge clk);
    go = 0;
    if (poke && busy) begin
      go = 1; func = 3'd7; unit = 1'(u ^ 1);
      @(negedge clk);
      go = 0;
    end
    t = 0;
    while (!cmp_valid && t < 4000) begin @(negedge clk); t++; end
    chk(tag, "flags", cmp_flags, ef);
    for (int k = 0; k < N; k++) chk(tag, "tape position", tpos[k], rpos[k]);
    if (ef[B_EMPTY] || ef[B_WLK]) chk(tag, "motion requests", nreq - r0, 0);
    repeat (3) @(negedge clk);
    chk(tag, "completions", ncmp - c0, 1);
  endtask

  function automatic string tag_of(int f);
    case (f)
      3, 5:    return "R8";
      4, 6:    return "R9";
      7:       return "R10";
      default: return "R11";
    endcase
  endfunction

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 0; go = 0; func = 0; unit = 0;
    present = 2'b11; wprot = 2'b00;
    for (int k = 0; k < N; k++) begin
      tpos[k] = 0; rhist[k] = 0;
      for (int i = 0; i < 16; i++) trec[k][i] = 0;
    end
    trec[0][0] = 1; trec[0][5] = 1; trec[1][7] = 1; trec[1][9] = 1;
    repeat (3) @(negedge clk);
    chk("R13", "reset busy", busy, 0);
    chk("R13", "reset req", mv_req, 0);
    chk("R13", "reset cmp", cmp_valid, 0);
    rst_n = 1;
    @(negedge clk);

    run_cmd("R4", 0, 2, 0);    // leading gap skipped, pos 2
    run_cmd("R4", 1, 2, 0);    // non-gap restored, pos 1
    run_cmd("R8", 0, 5, 0);    // to gap at 5, pos 6
    run_cmd("R5", 0, 4, 0);    // reversal skip then step, pos 4
    run_cmd("R6", 0, 5, 0);    // no skip, pos 6 eof
    run_cmd("R6", 0, 1, 0);    // write clears history
    run_cmd("R6", 0, 4, 0);    // no skip after write
    run_cmd("R12", 1, 5, 1);   // GO while busy ignored
    run_cmd("R11", 1, 2, 0);
    run_cmd("R11", 1, 2, 0);   // reads gap at 9
    run_cmd("R9", 1, 6, 0);
    run_cmd("R9", 1, 6, 0);    // reaches end
    foreach (tpos[k]) if (k == 1) chk("R7", "at end", tpos[k], LEN);
    for (int f = 0; f <= 6; f++) if (f != 3 && f != 4) run_cmd("R7", 1, f, 0);
    run_cmd("R10", 1, 7, 0);
    run_cmd("R1", 1, 3, 0);
    run_cmd("R1", 1, 4, 0);
    wprot = 2'b01;
    run_cmd("R3", 0, 1, 0);
    run_cmd("R3", 0, 0, 0);
    run_cmd("R3", 0, 2, 0);
    wprot = 2'b00;
    present = 2'b01;
    run_cmd("R2", 1, 2, 0);
    run_cmd("R2", 1, 7, 0);
    present = 2'b11;

    for (int k = 0; k < N; k++)
      for (int i = 0; i < 16; i++) trec[k][i] = ($urandom % 4 == 0);
    for (int n = 0; n < 400; n++) begin
      int u, f;
      if ($urandom % 20 == 0) present = 2'b11 ^ 2'($urandom % 3);
      if ($urandom % 10 == 0) wprot = 2'($urandom % 4);
      u = $urandom % 2;
      f = $urandom % 8;
      run_cmd(tag_of(f), u, f, 0);
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule